// File: doc/BRIEF.md
# Multi-Core External Interrupt Router

This block takes 256 level-sensitive interrupt lines from the chip's peripherals and steers each one to one of four cores. Each core has eight interrupt output pins. Routing has two stages. Each group of 32 neighbouring sources shares one output-pin selection. Each individual source has its own core selection. Each core has a pending-status bank with one bit per source. A core's output pin is high while any pending bit of that core belongs to a group routed to that pin.

Software sets up the block through a simple 32-bit register port with word addressing: a write strobe, an address, write data and combinational read data. Most banks are plain read/write words. The per-core status banks clear on a write of one. A write that clears an enable bit withdraws the pending state of that source at once. Two banks, node-type and bounce, are kept only so that software can read back what it wrote. They do not affect routing.

Top module: `ext_irq_router`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every register, so all reads return 0 and all of `core_irq` is 0 from the next edge.
- R2: A rising source whose enable bit (enable word n/32, bit n%32, at 0x200 + 4·(n/32)) is 0 at that edge sets no status bit in any core.
- R3: A source is sampled at each clock edge. A 0→1 transition of an enabled source sets its bit in the selected core's status bank at that edge. A 1→0 transition clears the source's bit in every core. A source that stays high sets nothing new.
- R4: Group g's pin field is byte g%4 of pin-map word g/4 (0x0C0, 0x0C4). The lowest set bit among its low 4 bits selects pin 0–3, and pin 0 is used when none of them is set. Pins 4–7 of every core stay low.
- R5: Source n's core field is byte n%4 of core-map word n/4 (0x800 + 4·(n/4)). The lowest set bit among its low 4 bits selects core 0–3, and core 0 is used when none of them is set.
- R6: A write to an enable word that turns a set bit to 0 clears that source's status bit in every core at the same edge.
- R7: Writing a word of core c's status bank (0x400 + 0x100·c + 4·w, w = 0..7) clears every status bit written as 1. When a clear and a set hit the same bit in the same cycle, the clear wins.
- R8: `core_irq` bit 8·c+p is the OR of core c's status bits over all groups routed to pin p. It follows the status registers combinationally, with no extra cycle.
- R9: Enable, pin-map, core-map and status words read back at their offsets as stored, with source bit n%32 at bit position n%32.
- R10: The node-type words (0x0A0–0x0BF) and bounce words (0x280–0x29F) read back what was written and do not change `core_irq`.
- R11: Reads from any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | 256 | Level of each external interrupt source |
| bus_wr | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 12 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| core_irq | output | 32 | Interrupt pins, bit 8·core + pin |

## Verification
Register writes, source edges, enable withdrawal and write-one-to-clear each act at the first clock edge after they are driven. Because `core_irq` is combinational from status, every one of these results appears on the pins one edge after the stimulus. Read data is combinational from the addressed register. The bench therefore drives on the falling edge and lets exactly one rising edge pass. It then checks pins and read data at the following falling edge, with no extra wait. A read check settles 1 ns after the address changes, without a clock edge in between.

// File: rtl/ext_irq_router_pkg.sv
// Package: shared constants, bank decode and the lowest-set-bit selector
// used by the external interrupt router. The address map is fixed, so
// decode works on fixed address bits of a 12-bit byte offset.
package ext_irq_router_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 12;
    localparam int SEL_W   = 2;

    typedef enum logic [2:0] {
        BANK_NONE,
        BANK_NODE,
        BANK_PIN,
        BANK_EN,
        BANK_BOUNCE,
        BANK_STAT,
        BANK_CMAP
    } bank_e;

    // Lowest set bit of the low nibble of a routing field, 0 when none set.
    function automatic logic [SEL_W-1:0] low4_pick(input logic [FIELD_W-1:0] fld);
        logic [SEL_W-1:0] r;
        r = '0;
        if (fld[0])      r = 2'd0;
        else if (fld[1]) r = 2'd1;
        else if (fld[2]) r = 2'd2;
        else if (fld[3]) r = 2'd3;
        return r;
    endfunction

    // Map a byte offset onto the bank it falls in.
    function automatic bank_e decode_bank(input logic [ADDR_W-1:0] a);
        bank_e b;
        b = BANK_NONE;
        if (a[11:5] == 7'h05)                        b = BANK_NODE;
        else if (a[11:3] == 9'h018)                  b = BANK_PIN;
        else if (a[11:5] == 7'h10)                   b = BANK_EN;
        else if (a[11:5] == 7'h14)                   b = BANK_BOUNCE;
        else if (a[11:10] == 2'b01 && a[7:5] == 3'b000) b = BANK_STAT;
        else if (a[11:8] == 4'h8)                    b = BANK_CMAP;
        return b;
    endfunction

endpackage

// File: rtl/ext_irq_cfg_regs.sv
// Module: configuration register file and read mux.
// Holds node-type, pin-map, enable, bounce and core-map words. It turns
// writes to the enable and status banks into per-bit clear masks for the
// status array. Assumes 32 sources per group and at most 4 cores and 8 groups.
module ext_irq_cfg_regs
    import ext_irq_router_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_GROUPS = 8,
    localparam int N_SRC   = N_GROUPS * WORD_W,
    localparam int N_PINW  = (N_GROUPS + 3) / 4,
    localparam int N_CMAPW = N_SRC / 4,
    localparam int N_NODEW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [N_CORES*N_SRC-1:0]   status,
    output logic [WORD_W-1:0]          rdata,
    output logic [N_SRC-1:0]           enable,
    output logic [N_GROUPS*FIELD_W-1:0] pin_fields,
    output logic [N_SRC*FIELD_W-1:0]   core_fields,
    output logic [N_SRC-1:0]           en_drop,
    output logic [N_CORES*N_SRC-1:0]   w1c_mask
);

    logic [WORD_W-1:0] node_q   [N_NODEW];
    logic [WORD_W-1:0] bounce_q [N_GROUPS];
    logic [WORD_W-1:0] en_q     [N_GROUPS];
    logic [WORD_W-1:0] pin_q    [N_PINW];
    logic [WORD_W-1:0] cmap_q   [N_CMAPW];

    bank_e bank;
    int    w8;
    int    wp;
    int    wc;
    int    core;

    // Decode the addressed bank and word indices.
    always_comb begin
        bank = decode_bank(addr);
        w8   = int'(addr[4:2]);
        wp   = int'(addr[2]);
        wc   = int'(addr[7:2]);
        core = int'(addr[9:8]);
    end

    // Register writes; every bank clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_NODEW; i++)  node_q[i]   <= '0;
            for (int i = 0; i < N_GROUPS; i++) bounce_q[i] <= '0;
            for (int i = 0; i < N_GROUPS; i++) en_q[i]     <= '0;
            for (int i = 0; i < N_PINW; i++)   pin_q[i]    <= '0;
            for (int i = 0; i < N_CMAPW; i++)  cmap_q[i]   <= '0;
        end else if (wr_en) begin
            case (bank)
                BANK_NODE:   node_q[w8] <= wdata;
                BANK_PIN:    if (wp < N_PINW)   pin_q[wp]    <= wdata;
                BANK_EN:     if (w8 < N_GROUPS) en_q[w8]     <= wdata;
                BANK_BOUNCE: if (w8 < N_GROUPS) bounce_q[w8] <= wdata;
                BANK_CMAP:   if (wc < N_CMAPW)  cmap_q[wc]   <= wdata;
                default: ;
            endcase
        end
    end

    // Combinational read data for the addressed word, 0 when unmapped.
    always_comb begin
        rdata = '0;
        case (bank)
            BANK_NODE:   rdata = node_q[w8];
            BANK_PIN:    if (wp < N_PINW)   rdata = pin_q[wp];
            BANK_EN:     if (w8 < N_GROUPS) rdata = en_q[w8];
            BANK_BOUNCE: if (w8 < N_GROUPS) rdata = bounce_q[w8];
            BANK_CMAP:   if (wc < N_CMAPW)  rdata = cmap_q[wc];
            BANK_STAT:   if (core < N_CORES && w8 < N_GROUPS)
                             rdata = status[core*N_SRC + w8*WORD_W +: WORD_W];
            default: ;
        endcase
    end

    // Enable bits turned off by this cycle's write.
    always_comb begin
        en_drop = '0;
        if (wr_en && bank == BANK_EN && w8 < N_GROUPS)
            en_drop[w8*WORD_W +: WORD_W] = en_q[w8] & ~wdata;
    end

    // Write-one-to-clear mask aimed at one core's status word.
    always_comb begin
        w1c_mask = '0;
        if (wr_en && bank == BANK_STAT && core < N_CORES && w8 < N_GROUPS)
            w1c_mask[core*N_SRC + w8*WORD_W +: WORD_W] = wdata;
    end

    // Flatten the word banks into routing vectors.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_en
        assign enable[g*WORD_W +: WORD_W] = en_q[g];
        assign pin_fields[g*FIELD_W +: FIELD_W] = pin_q[g/4][(g%4)*FIELD_W +: FIELD_W];
    end
    for (genvar w = 0; w < N_CMAPW; w++) begin : g_cmap
        assign core_fields[w*WORD_W +: WORD_W] = cmap_q[w];
    end

endmodule

// File: rtl/ext_irq_status.sv
// Module: per-core pending status array with source edge detection.
// Samples every source each clock. A rising, enabled source sets its bit in
// the selected core. A falling source, an enable withdrawal or a
// write-one-to-clear clears bits. Clears take priority over sets.
module ext_irq_status
    import ext_irq_router_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int N_SRC   = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         src_level,
    input  logic [N_SRC-1:0]         enable,
    input  logic [N_SRC*SEL_W-1:0]   core_sel,
    input  logic [N_SRC-1:0]         en_drop,
    input  logic [N_CORES*N_SRC-1:0] w1c_mask,
    output logic [N_CORES*N_SRC-1:0] status
);

    logic [N_SRC-1:0] src_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] fall;

    // Previous sampled level of every source.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_level;
    end

    assign rise = src_level & ~src_q;
    assign fall = ~src_level & src_q;

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic [N_SRC-1:0] hit;
        logic [N_SRC-1:0] stat_q;

        // Sources whose core field selects this core.
        always_comb begin
            for (int n = 0; n < N_SRC; n++)
                hit[n] = (core_sel[n*SEL_W +: SEL_W] == SEL_W'(c));
        end

        // Status bank for this core: set on routed rise, clear has priority.
        always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= (stat_q | (rise & enable & hit))
                                  & ~(fall | en_drop | w1c_mask[c*N_SRC +: N_SRC]);
        end

        assign status[c*N_SRC +: N_SRC] = stat_q;
    end

endmodule

// File: rtl/ext_irq_route.sv
// Module: decodes the core and pin fields and forms the output pins.
// Purely combinational. Each core pin is the OR of that core's status
// groups routed to it. Assumes at least 4 pins per core.
module ext_irq_route
    import ext_irq_router_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_GROUPS = 8,
    parameter int N_PINS   = 8,
    localparam int N_SRC   = N_GROUPS * WORD_W
) (
    input  logic [N_GROUPS*FIELD_W-1:0] pin_fields,
    input  logic [N_SRC*FIELD_W-1:0]    core_fields,
    input  logic [N_CORES*N_SRC-1:0]    status,
    output logic [N_SRC*SEL_W-1:0]      core_sel,
    output logic [N_CORES*N_PINS-1:0]   core_irq
);

    logic [SEL_W-1:0] grp_pin [N_GROUPS];

    // Core selection for every source.
    for (genvar n = 0; n < N_SRC; n++) begin : g_csel
        assign core_sel[n*SEL_W +: SEL_W] = low4_pick(core_fields[n*FIELD_W +: FIELD_W]);
    end

    // Pin selection for every group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_psel
        assign grp_pin[g] = low4_pick(pin_fields[g*FIELD_W +: FIELD_W]);
    end

    // OR the pending groups of each core onto their routed pins.
    always_comb begin
        core_irq = '0;
        for (int c = 0; c < N_CORES; c++)
            for (int g = 0; g < N_GROUPS; g++)
                if (|status[c*N_SRC + g*WORD_W +: WORD_W])
                    core_irq[c*N_PINS + int'(grp_pin[g])] = 1'b1;
    end

endmodule

// File: rtl/ext_irq_router.sv
// Module: top of the multi-core external interrupt router.
// Connects the register file, the status array and the routing logic.
// Assumes a single clock, synchronous active-low reset and word-aligned
// 32-bit register accesses.
module ext_irq_router
    import ext_irq_router_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int N_GROUPS = 8,
    parameter int N_PINS   = 8,
    localparam int N_SRC   = N_GROUPS * WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          src_level,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [WORD_W-1:0]         bus_wdata,
    output logic [WORD_W-1:0]         bus_rdata,
    output logic [N_CORES*N_PINS-1:0] core_irq
);

    logic [N_SRC-1:0]            enable_all;
    logic [N_GROUPS*FIELD_W-1:0] pin_fields;
    logic [N_SRC*FIELD_W-1:0]    core_fields;
    logic [N_SRC-1:0]            en_drop;
    logic [N_CORES*N_SRC-1:0]    w1c_mask;
    logic [N_CORES*N_SRC-1:0]    status_all;
    logic [N_SRC*SEL_W-1:0]      core_sel;

    ext_irq_cfg_regs #(.N_CORES(N_CORES), .N_GROUPS(N_GROUPS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .status      (status_all),
        .rdata       (bus_rdata),
        .enable      (enable_all),
        .pin_fields  (pin_fields),
        .core_fields (core_fields),
        .en_drop     (en_drop),
        .w1c_mask    (w1c_mask)
    );

    ext_irq_status #(.N_CORES(N_CORES), .N_SRC(N_SRC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .enable    (enable_all),
        .core_sel  (core_sel),
        .en_drop   (en_drop),
        .w1c_mask  (w1c_mask),
        .status    (status_all)
    );

    ext_irq_route #(.N_CORES(N_CORES), .N_GROUPS(N_GROUPS), .N_PINS(N_PINS)) u_route (
        .pin_fields  (pin_fields),
        .core_fields (core_fields),
        .status      (status_all),
        .core_sel    (core_sel),
        .core_irq    (core_irq)
    );

endmodule

// File: rtl/ext_irq_router_chk.sv
// Module: assertion checker bound to the router top. It observes the pins,
// the status array, the enables and the clear mask and checks the routing
// invariants over time.
module ext_irq_router_chk #(
    parameter int N_CORES = 4,
    parameter int N_SRC   = 256,
    parameter int N_PINS  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_SRC-1:0]         src_level,
    input logic [N_CORES*N_PINS-1:0] core_irq,
    input logic [N_CORES*N_SRC-1:0] status,
    input logic [N_SRC-1:0]         enable,
    input logic [N_CORES*N_SRC-1:0] w1c
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> core_irq == '0); // R1

    for (genvar c = 0; c < N_CORES; c++) begin : g_chk
        AST_NO_SET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            (status[c*N_SRC +: N_SRC] & ~$past(status[c*N_SRC +: N_SRC]) & ~$past(enable)) == '0); // R2

        AST_PENDING_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (status[c*N_SRC +: N_SRC] & ~$past(src_level)) == '0); // R3

        AST_UPPER_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            core_irq[c*N_PINS + 4 +: N_PINS-4] == '0); // R4

        AST_PENDING_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (status[c*N_SRC +: N_SRC] & ~enable) == '0); // R6

        AST_W1C_TAKES_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
            (status[c*N_SRC +: N_SRC] & $past(w1c[c*N_SRC +: N_SRC])) == '0); // R7
    end

endmodule

bind ext_irq_router ext_irq_router_chk #(
    .N_CORES (N_CORES),
    .N_SRC   (N_SRC),
    .N_PINS  (N_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_level (src_level),
    .core_irq  (core_irq),
    .status    (status_all),
    .enable    (enable_all),
    .w1c       (w1c_mask)
);

// File: tb/ext_irq_router_bench.sv
// Bench: vector table walked by one loop, then directed reset and
// priority tests. Inputs change on the falling edge and results are
// sampled on the falling edge after one rising edge.
module ext_irq_router_bench;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] src_level;
    logic         bus_wr;
    logic [11:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [31:0]  core_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ext_irq_router u_ext_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_level (src_level),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .core_irq  (core_irq)
    );

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_SRC = 2'd2;
    localparam logic [1:0] OP_IRQ = 2'd3;
    localparam int NV = 49;

    // {req, op, addr/source, data/level, expected}
    localparam logic [81:0] VEC [NV] = '{
        {4'd0,  OP_WR,  12'h200, 32'h0000_0007, 32'h0},
        {4'd9,  OP_RD,  12'h200, 32'h0,         32'h0000_0007}, // R9
        {4'd0,  OP_WR,  12'h800, 32'h001A_0CF0, 32'h0},
        {4'd9,  OP_RD,  12'h800, 32'h0,         32'h001A_0CF0},
        {4'd0,  OP_WR,  12'h0C0, 32'h0000_0008, 32'h0},
        {4'd0,  OP_SRC, 12'd1,   32'h1,         32'h0},
        {4'd5,  OP_IRQ, 12'h0,   32'h0,         32'h0008_0000}, // R5 field 0x0C -> core 2
        {4'd3,  OP_RD,  12'h600, 32'h0,         32'h0000_0002},
        {4'd0,  OP_SRC, 12'd2,   32'h1,         32'h0},
        {4'd5,  OP_IRQ, 12'h0,   32'h0,         32'h0008_0800}, // field 0x1A -> core 1
        {4'd0,  OP_SRC, 12'd0,   32'h1,         32'h0},
        {4'd5,  OP_IRQ, 12'h0,   32'h0,         32'h0008_0808}, // field 0xF0 -> core 0
        {4'd0,  OP_SRC, 12'd3,   32'h1,         32'h0},
        {4'd2,  OP_IRQ, 12'h0,   32'h0,         32'h0008_0808},
        {4'd2,  OP_RD,  12'h400, 32'h0,         32'h0000_0001},
        {4'd0,  OP_WR,  12'h600, 32'hFFFF_FFFF, 32'h0},
        {4'd7,  OP_IRQ, 12'h0,   32'h0,         32'h0000_0808},
        {4'd7,  OP_RD,  12'h600, 32'h0,         32'h0},
        {4'd7,  OP_RD,  12'h500, 32'h0,         32'h0000_0004},
        {4'd0,  OP_SRC, 12'd2,   32'h0,         32'h0},
        {4'd3,  OP_IRQ, 12'h0,   32'h0,         32'h0000_0008},
        {4'd3,  OP_RD,  12'h500, 32'h0,         32'h0},
        {4'd0,  OP_WR,  12'h200, 32'h0000_0006, 32'h0},
        {4'd6,  OP_IRQ, 12'h0,   32'h0,         32'h0},
        {4'd6,  OP_RD,  12'h400, 32'h0,         32'h0},
        {4'd0,  OP_WR,  12'h200, 32'h0000_0007, 32'h0},
        {4'd3,  OP_IRQ, 12'h0,   32'h0,         32'h0},          // held level sets nothing
        {4'd0,  OP_WR,  12'h204, 32'h0000_0100, 32'h0},
        {4'd0,  OP_WR,  12'h828, 32'h0000_0001, 32'h0},
        {4'd0,  OP_WR,  12'h0C0, 32'h0000_0208, 32'h0},
        {4'd0,  OP_SRC, 12'd40,  32'h1,         32'h0},
        {4'd4,  OP_IRQ, 12'h0,   32'h0,         32'h0000_0002},
        {4'd3,  OP_RD,  12'h404, 32'h0,         32'h0000_0100},
        {4'd0,  OP_WR,  12'h21C, 32'h8000_0000, 32'h0},
        {4'd0,  OP_WR,  12'h8FC, 32'h0800_0000, 32'h0},
        {4'd0,  OP_WR,  12'h0C4, 32'h0400_0000, 32'h0},
        {4'd0,  OP_SRC, 12'd255, 32'h1,         32'h0},
        {4'd8,  OP_IRQ, 12'h0,   32'h0,         32'h0400_0002}, // R8 pins of two cores
        {4'd9,  OP_RD,  12'h71C, 32'h0,         32'h8000_0000},
        {4'd0,  OP_WR,  12'h0A4, 32'h1234_5678, 32'h0},
        {4'd10, OP_RD,  12'h0A4, 32'h0,         32'h1234_5678}, // R10
        {4'd0,  OP_WR,  12'h29C, 32'hCAFE_0001, 32'h0},
        {4'd10, OP_RD,  12'h29C, 32'h0,         32'hCAFE_0001},
        {4'd10, OP_IRQ, 12'h0,   32'h0,         32'h0400_0002},
        {4'd0,  OP_WR,  12'h0C8, 32'hFFFF_FFFF, 32'h0},
        {4'd11, OP_RD,  12'h0C8, 32'h0,         32'h0},          // R11
        {4'd11, OP_RD,  12'h0C0, 32'h0,         32'h0000_0208},
        {4'd11, OP_RD,  12'h420, 32'h0,         32'h0},
        {4'd11, OP_IRQ, 12'h0,   32'h0,         32'h0400_0002}
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic read_check(input int req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, $sformatf("read 0x%03h", a), bus_rdata, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        src_level = '0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        @(negedge clk);
        tick();
        tick();
        // R1: reset state
        check(1, "pins after reset", core_irq, 32'h0);
        read_check(1, 12'h200, 32'h0);
        read_check(1, 12'h800, 32'h0);
        rst_n = 1'b1;
        tick();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  req;
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] d;
            logic [31:0] e;
            {req, op, a, d, e} = VEC[i];
            case (op)
                OP_WR:  bus_write(a, d);
                OP_RD:  read_check(int'(req), a, e);
                OP_SRC: begin
                    src_level[a[7:0]] = d[0];
                    tick();
                end
                default: check(int'(req), $sformatf("pins at vector %0d", i), core_irq, e);
            endcase
        end

        // R1: reset in mid-run with sources held high
        rst_n = 1'b0;
        tick();
        check(1, "pins after mid-run reset", core_irq, 32'h0);
        read_check(1, 12'h204, 32'h0);
        read_check(1, 12'h8FC, 32'h0);
        rst_n = 1'b1;
        tick();
        // R2: high sources after reset are disabled
        check(2, "pins with sources high, all disabled", core_irq, 32'h0);

        // R7: clear beats a same-cycle set; default maps route to core 0 pin 0
        src_level = '0;
        tick();
        bus_write(12'h200, 32'h0000_0020);
        src_level[5] = 1'b1;
        bus_write(12'h400, 32'h0000_0020);
        check(7, "pins after clear and set on one edge", core_irq, 32'h0);
        read_check(7, 12'h400, 32'h0);
        src_level[5] = 1'b0;
        tick();
        src_level[5] = 1'b1;
        tick();
        // R4 and R5: empty fields fall back to core 0, pin 0
        check(4, "pins with empty maps", core_irq, 32'h0000_0001);
        read_check(5, 12'h400, 32'h0000_0020);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule